// File: doc/BRIEF.md
# Memory-Mapped Register Router

A bus-slave block that turns requests from a simple valid/ready request channel into accesses on a small map of control registers. Each request carries a read flag, a byte address, a beat of write data and a per-byte write mask. The block returns one response per request on a valid/ready response channel. A response carries read data and an error flag. The device claims a 4 KiB window at base 0x1001_9000. Inside that window, addresses resolve to 8-byte beats.

The map is built from registers of different widths. Several narrow fields can sit in one beat. Beat 0 holds a 64-bit register. Beat 1 packs four things little-endian: a 32-bit register, a 16-bit register and two 4-bit fields. Every field in a beat is read or written in the same access. A parameter selects the depth of a request queue placed ahead of the register stage. With depth 0 the queue is left out, and requests pass straight through to the register stage.

Top module: `regmap_router`

## Requirements
- R1: After reset every register reads zero and `rsp_valid_o` is low.
- R2: Beat 0 (window offsets 0x00-0x07) is a 64-bit register that occupies byte lanes 0-7.
- R3: In beat 1 (offsets 0x08-0x0F) the lanes are assigned as follows. The 32-bit register uses lanes 0-3. The 16-bit register uses lanes 4-5. The two 4-bit fields use lane 6. Lane 7 reads zero. Address bits [2:0] do not affect which beat is selected.
- R4: The two 4-bit fields are packed little-endian. Field 0 is data bits [51:48] and field 1 is bits [55:52]. Writing 0xAB to lane 6 stores 0xB in field 0 and 0xA in field 1, and both change in the same access.
- R5: A write updates only the bytes whose bit in `req_mask_i` is 1. Bit i of the mask enables data bits [8i+7:8i].
- R6: Inside the window, offsets 0x10-0xFFF read zero and ignore writes. Their responses have `rsp_err_o` low.
- R7: An address outside the window gives a response with `rsp_err_o` high and zero read data, and it changes no register.
- R8: Every accepted request produces exactly one response, in acceptance order. A read response carries the register contents as they stand after all earlier writes. A write response carries zero data.
- R9: With queue depth 0, `req_ready_o` equals `!rsp_valid_o || rsp_ready_i`. With depth D>0, at most D+1 requests are outstanding, and `req_ready_o` is low at that limit.
- R10: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response stays valid and its data and error flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 64 | Write data beat |
| req_mask_i | input | 8 | Per-byte write enable |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken when high with valid |
| rsp_rdata_o | output | 64 | Read data (zero for writes and errors) |
| rsp_err_o | output | 1 | Address was outside the window |

## Verification
The assertions check four things on every cycle. A stalled response must hold its data and error flag. An error response must carry zero data. The count of outstanding requests must never exceed the queue depth plus one. At the depth-0 variant, the ready signal must follow the response handshake. Only the bench scenarios can show the contents of the map. They cover the byte-lane sweeps over the 64-bit register and the packed beat, the nibble split of the shared lane, the unmapped and out-of-window sweeps leaving registers intact, and in-order delivery after back-pressure.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int ADDR_W     = 32;
  localparam int BEAT_BYTES = 8;
  localparam int DATA_W     = 8 * BEAT_BYTES;

  typedef struct packed {
    logic                  rd;
    logic [ADDR_W-1:0]     addr;
    logic [DATA_W-1:0]     wdata;
    logic [BEAT_BYTES-1:0] mask;
  } req_t;
endpackage

// File: rtl/regmap_fifo.sv
module regmap_fifo
  import regmap_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  req_t data_i,
  output logic full_o,
  input  logic pop_i,
  output logic valid_o,
  output req_t data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  req_t          mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/regmap_decode.sv
module regmap_decode
  import regmap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1001_9000,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 32'h0000_0FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output logic              sel_wide_o,
  output logic              sel_pack_o
);
  localparam int OFF_W = $clog2(WIN_MASK + 1);
  localparam int SH    = $clog2(BEAT_BYTES);
  localparam int BW    = OFF_W - SH;

  logic [BW-1:0] beat;
  logic          unused_lo;

  assign unused_lo  = ^addr_i[SH-1:0];
  assign beat       = addr_i[OFF_W-1:SH];
  assign in_win_o   = ((addr_i & ~WIN_MASK) == (BASE_ADDR & ~WIN_MASK));
  assign sel_wide_o = in_win_o && (beat == BW'(0));
  assign sel_pack_o = in_win_o && (beat == BW'(1));
endmodule

// File: rtl/regmap_regs.sv
module regmap_regs
  import regmap_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  sel_wide_i,
  input  logic                  sel_pack_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [BEAT_BYTES-1:0] mask_i,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [63:0] wide_q;
  logic [31:0] word_q;
  logic [15:0] half_q;
  logic [3:0]  nib0_q, nib1_q;
  logic [63:0] pack_img, pack_nxt, wide_nxt;

  // beat 1 image: lanes 0-3 word, 4-5 half, 6 nibbles, 7 empty
  assign pack_img = {8'h00, nib1_q, nib0_q, half_q, word_q};

  always_comb begin
    for (int i = 0; i < BEAT_BYTES; i++) begin
      wide_nxt[8*i +: 8] = mask_i[i] ? wdata_i[8*i +: 8] : wide_q[8*i +: 8];
      pack_nxt[8*i +: 8] = mask_i[i] ? wdata_i[8*i +: 8] : pack_img[8*i +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= '0;
      word_q <= '0;
      half_q <= '0;
      nib0_q <= '0;
      nib1_q <= '0;
    end else if (we_i) begin
      if (sel_wide_i) wide_q <= wide_nxt;
      if (sel_pack_i) begin
        word_q <= pack_nxt[31:0];
        half_q <= pack_nxt[47:32];
        nib0_q <= pack_nxt[51:48];
        nib1_q <= pack_nxt[55:52];
      end
    end
  end

  always_comb begin
    if (sel_wide_i)      rdata_o = wide_q;
    else if (sel_pack_i) rdata_o = pack_img;
    else                 rdata_o = '0;
  end
endmodule

// File: rtl/regmap_router.sv
module regmap_router
  import regmap_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h1001_9000,
  parameter logic [31:0] WIN_MASK  = 32'h0000_0FFF,
  parameter int          DEPTH     = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_read_i,
  input  logic [31:0] req_addr_i,
  input  logic [63:0] req_wdata_i,
  input  logic [7:0]  req_mask_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [63:0] rsp_rdata_o,
  output logic        rsp_err_o
);
  req_t        in_req, head;
  logic        head_valid, take;
  logic        in_win, sel_wide, sel_pack;
  logic [63:0] reg_rdata;
  logic        rsp_valid_q, rsp_err_q;
  logic [63:0] rsp_rdata_q;

  assign in_req = '{rd: req_read_i, addr: req_addr_i, wdata: req_wdata_i, mask: req_mask_i};
  assign take   = head_valid && (!rsp_valid_q || rsp_ready_i);

  generate
    if (DEPTH == 0) begin : g_direct
      assign head_valid  = req_valid_i;
      assign head        = in_req;
      assign req_ready_o = !rsp_valid_q || rsp_ready_i;
    end else begin : g_queue
      logic full;
      regmap_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (req_valid_i && !full),
        .data_i  (in_req),
        .full_o  (full),
        .pop_i   (take),
        .valid_o (head_valid),
        .data_o  (head)
      );
      assign req_ready_o = !full;
    end
  endgenerate

  regmap_decode #(.BASE_ADDR(BASE_ADDR), .WIN_MASK(WIN_MASK)) u_dec (
    .addr_i     (head.addr),
    .in_win_o   (in_win),
    .sel_wide_o (sel_wide),
    .sel_pack_o (sel_pack)
  );

  regmap_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (take && !head.rd),
    .sel_wide_i (sel_wide),
    .sel_pack_i (sel_pack),
    .wdata_i    (head.wdata),
    .mask_i     (head.mask),
    .rdata_o    (reg_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (take) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= !in_win;
      rsp_rdata_q <= head.rd ? reg_rdata : '0;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;
endmodule

// File: rtl/regmap_router_chk.sv
module regmap_router_chk #(
  parameter int DEPTH = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [63:0] rsp_rdata_o,
  input logic        rsp_err_o
);
  localparam int OW = $clog2(DEPTH + 3);
  logic [OW-1:0] outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else outst_q <= outst_q + OW'(req_valid_i && req_ready_o) - OW'(rsp_valid_o && rsp_ready_i);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_idle_in_reset_R1: assert (!rsp_valid_o);
  end

  assert_rsp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o));

  assert_err_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == 64'h0);

  assert_rsp_has_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> outst_q != '0);

  assert_outst_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q <= OW'(DEPTH + 1));

  generate
    if (DEPTH == 0) begin : g_direct
      assert_ready_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o == (!rsp_valid_o || rsp_ready_i));
    end else begin : g_queue
      assert_full_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        outst_q == OW'(DEPTH + 1) |-> !req_ready_o);
    end
  endgenerate
endmodule

bind regmap_router regmap_router_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/regmap_router_test.sv
`timescale 1ns/1ps
module regmap_router_test;
  localparam logic [31:0] BASE = 32'h1001_9000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 0, req_read = 0, rsp_ready = 0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_mask = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  logic        n_valid = 0, n_rsp_ready = 0;
  logic        n_ready, n_rsp_valid, n_err;
  logic [63:0] n_rdata;

  int errors = 0, checks = 0;
  logic [63:0] wide_m = '0, pack_m = '0;

  always #2.5 clk = ~clk;

  regmap_router #(.DEPTH(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_read_i(req_read), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_mask_i(req_mask), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err));

  regmap_router #(.DEPTH(0)) uut_nq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(n_valid), .req_ready_o(n_ready),
    .req_read_i(1'b1), .req_addr_i(BASE + 32'h8), .req_wdata_i(64'h0),
    .req_mask_i(8'h00), .rsp_valid_o(n_rsp_valid), .rsp_ready_i(n_rsp_ready),
    .rsp_rdata_o(n_rdata), .rsp_err_o(n_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [31:0] a, input logic [63:0] d,
                      input logic [7:0] m, output logic [63:0] rdat, output logic err);
    @(negedge clk);
    req_valid = 1; req_read = rd; req_addr = a; req_wdata = d; req_mask = m; rsp_ready = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rdat = rsp_data_snap();
    err  = rsp_err;
  endtask

  function automatic logic [63:0] rsp_data_snap();
    return rsp_rdata;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic [7:0] m, input logic [7:0] live);
    logic [63:0] r;
    for (int i = 0; i < 8; i++)
      r[8*i +: 8] = (m[i] && live[i]) ? d[8*i +: 8] : old[8*i +: 8];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic        er;
    logic [63:0] d, hold;
    int          n;

    // R1 reset state
    @(negedge clk);
    chk(!rsp_valid && !n_rsp_valid, "R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    xfer(1, BASE, 0, 0, rd, er);
    chk(rd == 0, "R1 wide reg reset", rd, 0);
    xfer(1, BASE + 8, 0, 0, rd, er);
    chk(rd == 0, "R1 packed beat reset", rd, 0);

    // R4 nibble split
    xfer(0, BASE + 32'hE, 64'h00AB_0000_0000_0000, 8'h40, rd, er);
    pack_m = merge(pack_m, 64'h00AB_0000_0000_0000, 8'h40, 8'h7F);
    chk(rd == 0, "R8 write response data", rd, 0);
    xfer(1, BASE + 32'hE, 0, 0, rd, er);
    chk(rd[51:48] == 4'hB, "R4 field0", {60'd0, rd[51:48]}, 64'hB);
    chk(rd[55:52] == 4'hA, "R4 field1", {60'd0, rd[55:52]}, 64'hA);

    // R2 R5 mask sweep on beat 0
    for (int m = 0; m < 256; m++) begin
      d = {8{m[7:0]}} ^ 64'h0123_4567_89AB_CDEF ^ {32'(m * 7919), 32'(m * 104729)};
      xfer(0, BASE + 32'(m % 8), d, m[7:0], rd, er);
      wide_m = merge(wide_m, d, m[7:0], 8'hFF);
      xfer(1, BASE, 0, 0, rd, er);
      chk(rd == wide_m && !er, "R2 R5 wide reg masked write", rd, wide_m);
    end

    // R3 R5 mask sweep on packed beat, lane 7 never stored
    for (int m = 0; m < 256; m++) begin
      d = ~({8{m[7:0]}} ^ 64'hFEDC_BA98_7654_3210) ^ {32'(m * 31), 32'(m * 65537)};
      xfer(0, BASE + 8 + 32'(m % 8), d, m[7:0], rd, er);
      pack_m = merge(pack_m, d, m[7:0], 8'h7F);
      xfer(1, BASE + 8 + 32'((m + 3) % 8), 0, 0, rd, er);
      chk(rd == pack_m && !er, "R3 R5 packed beat masked write", rd, pack_m);
    end

    // R6 unmapped beats in window
    for (int b = 2; b < 512; b++) begin
      xfer(0, BASE + 32'(b * 8), 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, rd, er);
      xfer(1, BASE + 32'(b * 8), 0, 0, rd, er);
      chk(rd == 0 && !er, "R6 unmapped offset reads zero", rd, 0);
    end
    xfer(1, BASE, 0, 0, rd, er);
    chk(rd == wide_m, "R6 wide reg untouched", rd, wide_m);
    xfer(1, BASE + 8, 0, 0, rd, er);
    chk(rd == pack_m, "R6 packed beat untouched", rd, pack_m);

    // R7 outside window
    xfer(0, BASE + 32'h1000, 64'h5555_5555_5555_5555, 8'hFF, rd, er);
    chk(er == 1, "R7 err above window", {63'd0, er}, 1);
    xfer(0, BASE - 32'h1000, 64'h5555_5555_5555_5555, 8'hFF, rd, er);
    chk(er == 1, "R7 err below window", {63'd0, er}, 1);
    xfer(1, BASE - 32'h1000, 0, 0, rd, er);
    chk(rd == 0 && er, "R7 read outside is zero", rd, 0);
    xfer(1, BASE, 0, 0, rd, er);
    chk(rd == wide_m, "R7 wide reg untouched", rd, wide_m);

    // R9 R10 R8 back-pressure with queue depth 2
    @(negedge clk);
    rsp_ready = 0;
    n = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      req_valid = 1; req_read = 1;
      req_addr = (n == 0) ? BASE : (n == 1) ? BASE + 8 : BASE + 32'h100;
      #1;
      if (req_ready) n++;
    end
    @(negedge clk);
    req_valid = 0;
    chk(n == 3, "R9 accepted with stalled response", 64'(n), 3);
    hold = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_rdata == hold, "R10 stalled response stable", rsp_rdata, hold);
    rsp_ready = 1;
    for (int k = 0; k < 3; k++) begin
      while (!rsp_valid) @(negedge clk);
      d = (k == 0) ? wide_m : (k == 1) ? pack_m : 64'h0;
      chk(rsp_rdata == d, "R8 in-order response", rsp_rdata, d);
      @(negedge clk);
    end

    // R9 depth-0 variant
    @(negedge clk);
    n_valid = 1; n_rsp_ready = 0;
    #1;
    chk(n_ready == 1, "R9 nq ready when idle", {63'd0, n_ready}, 1);
    @(negedge clk);
    n_valid = 0;
    #1;
    chk(n_rsp_valid && !n_ready, "R9 nq ready low while stalled", {63'd0, n_ready}, 0);
    chk(n_rdata == 0 && !n_err, "R1 nq packed beat zero", n_rdata, 0);
    n_rsp_ready = 1;
    #1;
    chk(n_ready == 1, "R9 nq ready follows rsp_ready", {63'd0, n_ready}, 1);
    @(negedge clk);
    #1;
    chk(!n_rsp_valid, "R8 nq single response", {63'd0, n_rsp_valid}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule